// File: doc/BRIEF.md
# Three-Lane Multi-Format PCM Serial Port

This block moves stereo PCM samples between a parallel core and three serial audio data lines in each direction. All six lines are timed by one external bit clock and one external frame (LR) clock. Both clocks are oversampled in the system clock domain. The block receives on the rising bit-clock edge and transmits on the falling edge.

The block supports three framings: I2S, left-justified and right-justified. Word lengths are 16, 18, 20 or 24 bits, and a frame holds either 16 or 32 bit slots per channel. One slot counter, shared by all three lanes, locates each bit from the LR transition that opens a frame. Each lane has its own shift and holding registers. Received samples leave the block MSB-aligned in 24-bit fields, with a one-cycle valid pulse for each completed frame. Transmit samples are taken in the same MSB-aligned layout.

Configuration is static. It is applied while reset is asserted and held for as long as the port runs.

Top module: `pcm_serial_port`

## Requirements
- R1: `fmtSel` selects the framing: 0 = I2S, where the word MSB is in the second slot after the LR transition; 1 or 3 = left-justified, where the MSB is in the first slot; 2 = right-justified, where the LSB is in the last slot of the half-frame. Receive and transmit always use the same framing.
- R2: Each frame begins with the left channel. The left half is LR high in the justified framings and LR low in I2S. A frame starts at the LR transition into the left level.
- R3: `wordSel` sets the word length: 0 = 16, 1 = 18, 2 = 20, 3 = 24 bits, sent MSB first. A received word appears MSB-aligned at bit 23 of its lane field, and the low 24−W bits read as zero.
- R4: `frame64` = 1 selects 32 slots per channel. `frame64` = 0 selects 16 slots per channel and forces a 16-bit word, whatever the value of `wordSel`.
- R5: Serial input is sampled on the rising bit-clock edge. Slots outside the word, and the low bits of a transmit sample beyond the word length, have no effect.
- R6: `rxValid` pulses for exactly one cycle per received frame, one cycle after the rising edge that carries the right word's LSB. All lanes' left and right outputs update only in that cycle.
- R7: `sdOut` changes only in the cycle after a falling bit-clock edge, and it drives 0 in every slot outside the word.
- R8: Both transmit samples of a frame are captured at the falling edge that starts the left word. The whole frame is then sent from those captured values.
- R9: After reset, `sdOut` stays 0 and no `rxValid` is raised until the first LR transition into the left level.
- R10: Lane i uses `sdIn[i]`, `sdOut[i]` and bits [24i+23:24i] of each sample bus. All three lanes run in lockstep.
- R11: Each bit-clock phase must last at least two system clocks, and configuration changes are made only under reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bclkIn | input | 1 | Serial bit clock |
| lrclkIn | input | 1 | LR (frame) clock |
| fmtSel | input | 2 | Framing select |
| wordSel | input | 2 | Word length select |
| frame64 | input | 1 | 1: 32 slots per channel, 0: 16 |
| sdIn | input | 3 | Serial data in, one bit per lane |
| txLeftFlat | input | 72 | Left transmit samples, 24 bits per lane |
| txRightFlat | input | 72 | Right transmit samples, 24 bits per lane |
| sdOut | output | 3 | Serial data out, one bit per lane |
| rxLeftFlat | output | 72 | Received left samples, 24 bits per lane |
| rxRightFlat | output | 72 | Received right samples, 24 bits per lane |
| rxValid | output | 1 | One-cycle pulse when a frame is complete |

## Verification
In I2S with 16 slots per channel, the right word's LSB falls in the first slot of the next frame. On that single rising edge, the completion of the previous frame's capture coincides with the LR resynchronisation that restarts the slot counter. On the transmit side, the wrapped LSB is sent from the holding register just before the next frame's samples are captured. Segments in this mode, and the trailing slots appended after each segment, provoke both collisions. They are judged by comparing every received word, and every transmitted slot of every frame after the first, against values the bench builds from random samples. The random padding bits must never leak into the results.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int SAMPLE_W   = 24;                 // widest word, field width
  localparam int MAX_HALF   = 32;                 // slots per channel, long frame
  localparam int POS_W      = $clog2(2 * MAX_HALF);
  localparam int BIT_IDX_W  = $clog2(SAMPLE_W);

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_ALT   = 2'd3
  } fmt_e;

  typedef struct packed {
    logic             rxShiftL;
    logic             rxShiftR;
    logic             rxCapture;
    logic             txDrive;
    logic             txLatch;
    logic             txActive;
    logic             txRight;
    logic [POS_W-1:0] txBit;
    logic [POS_W-1:0] wordLen;
  } pcm_strobe_t;

  function automatic logic [POS_W-1:0] wordLenOf(input logic [1:0] sel, input logic longFrame);
    logic [POS_W-1:0] len;
    case (sel)
      2'd0: len = POS_W'(16);
      2'd1: len = POS_W'(18);
      2'd2: len = POS_W'(20);
      default: len = POS_W'(24);
    endcase
    return longFrame ? len : POS_W'(16);
  endfunction
endpackage

// File: rtl/pcm_port_ctrl.sv
module pcm_port_ctrl
  import pcm_port_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bclkIn,
  input  logic        lrclkIn,
  input  logic [1:0]  fmtSel,
  input  logic [1:0]  wordSel,
  input  logic        frame64,
  output pcm_strobe_t stb,
  output logic        syncOk
);
  localparam logic [POS_W-1:0] HALF_LONG  = POS_W'(MAX_HALF);
  localparam logic [POS_W-1:0] HALF_SHORT = POS_W'(MAX_HALF / 2);

  logic bclkQ, lrPrev, prevOk;
  logic [POS_W-1:0] pos, posNext, halfLen, posMask, wordLen, offset, relRx, relTx;
  logic rise, fall, leftLvl, lrEdge, lockNext, rxGo, txGo, txInL, txInR;

  always_comb begin
    rise     = bclkIn & ~bclkQ;
    fall     = ~bclkIn & bclkQ;
    halfLen  = frame64 ? HALF_LONG : HALF_SHORT;
    posMask  = (halfLen << 1) - POS_W'(1);
    wordLen  = wordLenOf(wordSel, frame64);
    case (fmt_e'(fmtSel))
      FMT_I2S:   offset = POS_W'(1);
      FMT_RIGHT: offset = halfLen - wordLen;
      default:   offset = '0;
    endcase
    leftLvl  = (fmt_e'(fmtSel) == FMT_I2S) ? ~lrclkIn : lrclkIn;
    lrEdge   = rise & prevOk & (lrclkIn != lrPrev);
    posNext  = lrEdge ? (leftLvl ? '0 : halfLen) : ((pos + POS_W'(1)) & posMask);
    lockNext = syncOk | (lrEdge & leftLvl);
    relRx    = (posNext - offset) & posMask;
    relTx    = (pos + POS_W'(1) - offset) & posMask;
    rxGo     = rise & lockNext;
    txGo     = fall & syncOk;
    txInL    = relTx < wordLen;
    txInR    = (relTx >= halfLen) && (relTx < halfLen + wordLen);

    stb.rxShiftL  = rxGo & (relRx < wordLen);
    stb.rxShiftR  = rxGo & (relRx >= halfLen) & (relRx < halfLen + wordLen);
    stb.rxCapture = rise & syncOk & (relRx == halfLen + wordLen - POS_W'(1));
    stb.txDrive   = txGo;
    stb.txLatch   = txGo & (relTx == '0);
    stb.txActive  = txInL | txInR;
    stb.txRight   = txInR;
    stb.txBit     = txInR ? (relTx - halfLen) : relTx;
    stb.wordLen   = wordLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkQ  <= 1'b0;
      lrPrev <= 1'b0;
      prevOk <= 1'b0;
      pos    <= '0;
      syncOk <= 1'b0;
    end else begin
      bclkQ <= bclkIn;
      if (rise) begin
        lrPrev <= lrclkIn;
        prevOk <= 1'b1;
        pos    <= posNext;
        syncOk <= lockNext;
      end
    end
  end
endmodule

// File: rtl/pcm_port_dp.sv
module pcm_port_dp
  import pcm_port_pkg::*;
#(
  parameter int LANES = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pcm_strobe_t               stb,
  input  logic [LANES-1:0]          sdIn,
  input  logic [LANES*SAMPLE_W-1:0] txLeftFlat,
  input  logic [LANES*SAMPLE_W-1:0] txRightFlat,
  output logic [LANES-1:0]          sdOut,
  output logic [LANES*SAMPLE_W-1:0] rxLeftFlat,
  output logic [LANES*SAMPLE_W-1:0] rxRightFlat,
  output logic                      rxValid
);
  logic [POS_W-1:0]     alignShift;
  logic [BIT_IDX_W-1:0] txIdx;

  assign alignShift = POS_W'(SAMPLE_W) - stb.wordLen;
  assign txIdx      = BIT_IDX_W'(SAMPLE_W - 1) - BIT_IDX_W'(stb.txBit);

  always_ff @(posedge clk) begin
    if (!rstN) rxValid <= 1'b0;
    else       rxValid <= stb.rxCapture;
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [SAMPLE_W-1:0] shL, shR, holdL, holdR, srcL, srcR, rightFull;
    logic                txBitVal;

    always_comb begin
      rightFull = {shR[SAMPLE_W-2:0], sdIn[ln]};
      srcL      = stb.txLatch ? txLeftFlat[ln*SAMPLE_W +: SAMPLE_W]  : holdL;
      srcR      = stb.txLatch ? txRightFlat[ln*SAMPLE_W +: SAMPLE_W] : holdR;
      txBitVal  = stb.txRight ? srcR[txIdx] : srcL[txIdx];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shL <= '0;
        shR <= '0;
        holdL <= '0;
        holdR <= '0;
        sdOut[ln] <= 1'b0;
        rxLeftFlat[ln*SAMPLE_W +: SAMPLE_W]  <= '0;
        rxRightFlat[ln*SAMPLE_W +: SAMPLE_W] <= '0;
      end else begin
        if (stb.rxShiftL) shL <= {shL[SAMPLE_W-2:0], sdIn[ln]};
        if (stb.rxShiftR) shR <= rightFull;
        if (stb.rxCapture) begin
          rxLeftFlat[ln*SAMPLE_W +: SAMPLE_W]  <= shL << alignShift;
          rxRightFlat[ln*SAMPLE_W +: SAMPLE_W] <= rightFull << alignShift;
        end
        if (stb.txLatch) begin
          holdL <= srcL;
          holdR <= srcR;
        end
        if (stb.txDrive) sdOut[ln] <= stb.txActive & txBitVal;
      end
    end
  end
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter int LANES = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      bclkIn,
  input  logic                      lrclkIn,
  input  logic [1:0]                fmtSel,
  input  logic [1:0]                wordSel,
  input  logic                      frame64,
  input  logic [LANES-1:0]          sdIn,
  input  logic [LANES*SAMPLE_W-1:0] txLeftFlat,
  input  logic [LANES*SAMPLE_W-1:0] txRightFlat,
  output logic [LANES-1:0]          sdOut,
  output logic [LANES*SAMPLE_W-1:0] rxLeftFlat,
  output logic [LANES*SAMPLE_W-1:0] rxRightFlat,
  output logic                      rxValid
);
  pcm_strobe_t stb;
  logic        syncOk;

  pcm_port_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .lrclkIn(lrclkIn),
    .fmtSel(fmtSel), .wordSel(wordSel), .frame64(frame64),
    .stb(stb), .syncOk(syncOk)
  );

  pcm_port_dp #(.LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdIn(sdIn),
    .txLeftFlat(txLeftFlat), .txRightFlat(txRightFlat),
    .sdOut(sdOut), .rxLeftFlat(rxLeftFlat), .rxRightFlat(rxRightFlat),
    .rxValid(rxValid)
  );
endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk
  import pcm_port_pkg::*;
#(
  parameter int LANES = 3
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      bclkIn,
  input logic [1:0]                wordSel,
  input logic                      frame64,
  input logic [LANES-1:0]          sdOut,
  input logic [LANES*SAMPLE_W-1:0] rxLeftFlat,
  input logic [LANES*SAMPLE_W-1:0] rxRightFlat,
  input logic                      rxValid,
  input logic                      syncOk
);
  logic [SAMPLE_W-1:0] lowMask;
  logic                lowClean;

  always_comb begin
    lowMask  = ~({SAMPLE_W{1'b1}} << (POS_W'(SAMPLE_W) - wordLenOf(wordSel, frame64)));
    lowClean = 1'b1;
    for (int ln = 0; ln < LANES; ln++) begin
      if (((rxLeftFlat[ln*SAMPLE_W +: SAMPLE_W] | rxRightFlat[ln*SAMPLE_W +: SAMPLE_W]) & lowMask) != '0)
        lowClean = 1'b0;
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R6
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((rxLeftFlat != $past(rxLeftFlat)) || (rxRightFlat != $past(rxRightFlat))) |-> rxValid); // R6
  AST_VALID_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> ($past(bclkIn) && !$past(bclkIn, 2))); // R5
  AST_TX_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (sdOut != $past(sdOut)) |-> (!$past(bclkIn) && $past(bclkIn, 2))); // R7
  AST_QUIET_UNSYNCED: assert property (@(posedge clk) disable iff (!rstN)
    !syncOk |-> ((sdOut == '0) && !rxValid)); // R9
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> lowClean); // R3
endmodule

bind pcm_serial_port pcm_serial_port_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/test_pcm_serial_port.sv
module test_pcm_serial_port;
  localparam int NF = 4;
  localparam int LN = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bclk = 1'b1, lr = 1'b0, frame64 = 1'b1;
  logic [1:0] fmtSel = '0, wordSel = '0;
  logic [LN-1:0] sdIn = '0;
  logic [LN*24-1:0] txL = '0, txR = '0;
  logic [LN-1:0] sdOut;
  logic [LN*24-1:0] rxL, rxR;
  logic rxValid;

  int nChk = 0, nFail = 0, rxCnt = 0;
  bit monOn = 0, done = 0;
  logic [23:0] segMask;
  logic [23:0] inL [0:NF][0:LN-1];
  logic [23:0] inR [0:NF][0:LN-1];
  logic [23:0] tL  [0:NF][0:LN-1];
  logic [23:0] tR  [0:NF][0:LN-1];

  always #10 clk = ~clk;

  pcm_serial_port i_pcm_serial_port (
    .clk(clk), .rstN(rstN), .bclkIn(bclk), .lrclkIn(lr),
    .fmtSel(fmtSel), .wordSel(wordSel), .frame64(frame64), .sdIn(sdIn),
    .txLeftFlat(txL), .txRightFlat(txR), .sdOut(sdOut),
    .rxLeftFlat(rxL), .rxRightFlat(rxR), .rxValid(rxValid)
  );

  function automatic int halfOf(bit f64); return f64 ? 32 : 16; endfunction
  function automatic int wordOf(int ws, bit f64);
    if (!f64) return 16;  // R4
    case (ws) 0: return 16; 1: return 18; 2: return 20; default: return 24; endcase
  endfunction
  function automatic int offOf(int fmt, int h, int w);
    if (fmt == 0) return 1;
    if (fmt == 2) return h - w;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // receive monitor: R3 R5 R10
  always @(negedge clk) begin
    if (monOn && rxValid) begin
      if (rxCnt >= NF) check(1'b0, "R6 extra rxValid", 72'(rxCnt), 72'(NF));
      else begin
        for (int i = 0; i < LN; i++) begin
          check(rxL[i*24 +: 24] == (inL[rxCnt][i] & segMask), "R3/R5/R10 left word",
                72'(rxL[i*24 +: 24]), 72'(inL[rxCnt][i] & segMask));
          check(rxR[i*24 +: 24] == (inR[rxCnt][i] & segMask), "R3/R5/R10 right word",
                72'(rxR[i*24 +: 24]), 72'(inR[rxCnt][i] & segMask));
        end
      end
      rxCnt++;
    end
  end

  // one bit slot: four system clocks low, four high (R11)
  task automatic doSlot(input logic lrv, input logic [LN-1:0] din,
                        input logic [LN-1:0] chk, input logic [LN-1:0] exp, input string req);
    @(negedge clk);
    bclk = 1'b0; lr = lrv; sdIn = din;
    repeat (3) @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < LN; i++)
      if (chk[i]) check(sdOut[i] == exp[i], req, 72'(sdOut[i]), 72'(exp[i]));
    bclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic runSeg(input int fmt, input int ws, input bit f64);
    int h, w, off, msk;
    logic lvl;
    h = halfOf(f64); w = wordOf(ws, f64); off = offOf(fmt, h, w); msk = 2 * h - 1;
    lvl = (fmt == 0) ? 1'b0 : 1'b1;  // R2
    rstN = 1'b0; bclk = 1'b1; lr = ~lvl;
    fmtSel = 2'(fmt); wordSel = 2'(ws); frame64 = f64;
    for (int f = 0; f <= NF; f++)
      for (int i = 0; i < LN; i++) begin
        inL[f][i] = 24'($urandom); inR[f][i] = 24'($urandom);
        tL[f][i]  = 24'($urandom); tR[f][i]  = 24'($urandom);
      end
    segMask = 24'hFFFFFF << (24 - w);
    rxCnt = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(sdOut == '0 && !rxValid && rxL == '0 && rxR == '0, "R9 reset state",
          {sdOut, rxValid, rxL[7:0]}, 72'(0));
    monOn = 1;
    for (int p = 0; p < h; p++) doSlot(~lvl, 3'($urandom), '1, '0, "R9 quiet before sync");
    for (int f = 0; f <= NF; f++) begin
      int lim;
      lim = (f == NF) ? 2 : 2 * h;
      for (int p = 0; p < lim; p++) begin
        logic [LN-1:0] din, chk, exp;
        int rel, own, k;
        bit inW, isR;
        if (p == 0)
          for (int i = 0; i < LN; i++) begin
            txL[i*24 +: 24] = tL[f][i]; txR[i*24 +: 24] = tR[f][i];
          end
        rel = (p - off) & msk;
        own = (p < off) ? f - 1 : f;
        inW = 0; isR = 0; k = 0;
        if (rel < w) begin inW = 1; k = rel; end
        else if (rel >= h && rel < h + w) begin inW = 1; isR = 1; k = rel - h; end
        din = 3'($urandom);  // padding is random: R5
        chk = '1; exp = '0;  // R7 zero outside the word
        for (int i = 0; i < LN; i++) begin
          if (inW && own >= 0) din[i] = isR ? inR[own][i][23-k] : inL[own][i][23-k];
          if (inW) begin
            if (own >= 1) exp[i] = isR ? tR[own][i][23-k] : tL[own][i][23-k];
            else chk[i] = 1'b0;
          end
        end
        doSlot((p < h) ? lvl : ~lvl, din, chk, exp, "R1/R2/R7/R8/R10 tx slot");
      end
    end
    repeat (8) @(negedge clk);
    monOn = 0;
    check(rxCnt == NF, "R6 frame count", 72'(rxCnt), 72'(NF));
  endtask

  initial begin
    void'($urandom(32'h1F2E3D));
    // directed: every framing and word length in long frames (R1 R3)
    for (int fm = 0; fm < 3; fm++)
      for (int ws = 0; ws < 4; ws++) runSeg(fm, ws, 1'b1);
    // short frames, incl. wrapped I2S LSB and 24-bit select forced to 16 (R4)
    for (int fm = 0; fm < 3; fm++) runSeg(fm, 0, 1'b0);
    runSeg(0, 3, 1'b0);
    runSeg(3, 2, 1'b1);  // alias code for left-justified (R1)
    for (int n = 0; n < 4; n++) runSeg(int'($urandom % 4), int'($urandom % 4), 1'($urandom));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R6 watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule